// File: doc/BRIEF.md
# Battery-Backed Key Register Controller

This block guards a secret key held in nine 32-bit words that a battery keeps alive across power loss. Software reaches it through a 32-bit APB-style register port. Key words can be loaded only after a magic-value unlock, and that unlock also wipes whatever key was there. Loaded key words never read back. The block can zeroize the key on request, and it tracks in a status bit whether the key is currently all zero.

The key words can be checked without being read. Software writes an expected checksum, and the block runs a bit-serial CRC-32C over key words 0 to 7, then reports done and pass flags. The ninth word is a special case. Depending on a configuration pin, it is either a secret word like the others or a readable word that can be frozen by a sticky lock. The same pin decides whether one zero word is fed through the CRC before the key. An access to an unmapped offset can be reported as a bus error and as a maskable level interrupt.

Key storage has no reset, so the key survives a controller reset. Every control and status bit does return to its reset value.

Top module: `keyvault_ctrl`

## Requirements
- R1: After reset, the status register (offset 0x00) reads 0, the mask register (0x3C) reads 1, the lock register (0x4C) reads 0 and `irq` is low. Key words keep the values they held before reset.
- R2: Writing exactly 0x757BDF0D to offset 0x08 zeroizes the key and sets status bit 0 (programming mode). Any other value has no effect. Only reset clears bit 0.
- R3: Writing 1 in bit 0 of offset 0x04 zeroizes the key. That register always reads 0.
- R4: Key words 0–7 sit at offsets 0x10–0x2C and take a write only while programming mode is set. They, and the checksum register at 0x0C, always read 0.
- R5: Zeroization clears words 0–7, and clears word 8 only when `cfgStrict` is 1. It sets status bit 4 (zeroized).
- R6: An accepted nonzero write to words 0–7 clears status bit 4. An accepted nonzero write to word 8 clears it only when `cfgStrict` is 1. Writes of zero leave it unchanged.
- R7: Word 8 (offset 0x30) ignores writes while programming mode is off or the lock is set. It reads 0 when `cfgStrict` is 1 and reads its stored value otherwise.
- R8: Writing 1 in bit 0 of offset 0x4C sets the lock, and only reset clears it. While `cfgStrict` is 1 the lock stays 0.
- R9: Writing offset 0x0C while programming mode is set and no check is running clears status bits 9 and 8 and starts a CRC-32C. The CRC uses the reflected polynomial 0x82F63B78, a start value of all ones and a final inversion. It runs one bit per clock, least significant bit of each word first, over words 0–7 in order, preceded by one zero word when `cfgStrict` is 1. At the end, bit 8 (done) is set and bit 9 (pass) shows whether the written value equals the CRC. A checksum write outside programming mode, or while a check runs, is ignored.
- R10: When bit 0 of offset 0x34 is 1, an access to an unmapped or misaligned offset returns `pslverr` and sets bit 0 of the interrupt status register at 0x38. When that bit is 0, neither happens. Unmapped reads return 0.
- R11: Interrupt status bit 0 clears when 1 is written to it. `irq` is high while status bit 0 is set and mask bit 0 is clear. Writing 1 to offset 0x40 clears the mask bit, and writing 1 to offset 0x44 sets it. Offsets 0x40 and 0x44 read 0.
- R12: `pready` is always 1, and a write takes effect at the clock edge that ends its access phase. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset for control and status state |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Error response for unmapped offsets |
| irq | output | 1 | Level interrupt |
| cfgStrict | input | 1 | 1: word 8 secret, no lock, zero word before CRC |

## Verification
Most internal faults here are silent until software looks. A stuck programming-mode or lock bit only shows on the next status read, or as a key write that was dropped. A dropped key write is visible only through the zeroized bit, or later as a failed CRC compare. A wrong CRC bit order or a wrong padding choice shows up about 256 or 288 cycles after the checksum write, as a pass flag that disagrees with the reference value. Interrupt faults show at `irq` right after the edge that ends the access.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;

  localparam int NUM_KEY_WORDS = 9;
  localparam int KIDX_W = $clog2(NUM_KEY_WORDS);

  // Word indices (byte offset / 4) of the register map
  localparam int IDX_STATUS = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_PGM    = 2;
  localparam int IDX_SUM    = 3;
  localparam int IDX_KEY0   = 4;
  localparam int IDX_KEYTOP = IDX_KEY0 + NUM_KEY_WORDS - 1;
  localparam int IDX_ERREN  = 13;
  localparam int IDX_ISR    = 14;
  localparam int IDX_IMR    = 15;
  localparam int IDX_IER    = 16;
  localparam int IDX_IDR    = 17;
  localparam int IDX_LOCK   = 19;

  localparam logic [31:0] PGM_MAGIC = 32'h757B_DF0D;
  localparam logic [31:0] CRC_POLY  = 32'h82F6_3B78;

  typedef struct packed {
    logic              keyWr;
    logic [KIDX_W-1:0] keyIdx;
    logic              zeroAll;
    logic              clrTop;
    logic              crcStart;
  } kvStrobe_t;

endpackage

// File: rtl/keyvault_dp.sv
module keyvault_dp
  import keyvault_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = NUM_KEY_WORDS,
  parameter logic [WORD_W-1:0] POLY = CRC_POLY
) (
  input  logic              clk,
  input  logic              rstN,
  input  kvStrobe_t         stb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              cfgPad,
  output logic [WORD_W-1:0] topWord,
  output logic              crcBusy,
  output logic              crcFinish,
  output logic              crcMatch
);

  localparam int CRC_WORDS = NUM_WORDS - 1;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int BITS_RAW  = CRC_WORDS * WORD_W;
  localparam int BITS_PAD  = BITS_RAW + WORD_W;
  localparam int CNT_W     = $clog2(BITS_PAD + 1);

  logic [WORD_W-1:0] keyMem [NUM_WORDS];

  // Key storage: deliberately no reset, contents survive controller reset
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic clearThis;
    if (i < NUM_WORDS - 1) begin : g_body
      assign clearThis = stb.zeroAll;
    end else begin : g_top
      assign clearThis = stb.zeroAll && stb.clrTop;
    end
    always_ff @(posedge clk) begin
      if (clearThis) keyMem[i] <= '0;
      else if (stb.keyWr && stb.keyIdx == KIDX_W'(i)) keyMem[i] <= wrData;
    end
  end

  assign topWord = keyMem[NUM_WORDS-1];

  // Bit-serial CRC engine
  logic              busyQ, padQ;
  logic [CNT_W-1:0]  bitCnt, dataIdx, wordSel, lastIdx;
  logic [BIT_W-1:0]  bitSel;
  logic [WORD_W-1:0] crcQ, sumQ, curWord, crcNext;
  logic              inPad, inBit, lastBit;

  assign inPad   = padQ && (bitCnt < CNT_W'(WORD_W));
  assign dataIdx = padQ ? bitCnt - CNT_W'(WORD_W) : bitCnt;
  assign wordSel = dataIdx >> BIT_W;
  assign bitSel  = dataIdx[BIT_W-1:0];
  assign lastIdx = padQ ? CNT_W'(BITS_PAD - 1) : CNT_W'(BITS_RAW - 1);
  assign lastBit = bitCnt == lastIdx;

  always_comb begin
    curWord = '0;
    for (int w = 0; w < CRC_WORDS; w++) begin
      if (wordSel == CNT_W'(w)) curWord = keyMem[w];
    end
  end

  assign inBit   = inPad ? 1'b0 : curWord[bitSel];
  assign crcNext = (crcQ >> 1) ^ ((crcQ[0] ^ inBit) ? POLY : '0);

  assign crcBusy   = busyQ;
  assign crcFinish = busyQ && lastBit;
  assign crcMatch  = ~crcNext == sumQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      padQ   <= 1'b0;
      bitCnt <= '0;
      crcQ   <= '1;
      sumQ   <= '0;
    end else if (stb.crcStart) begin
      busyQ  <= 1'b1;
      padQ   <= cfgPad;
      bitCnt <= '0;
      crcQ   <= '1;
      sumQ   <= wrData;
    end else if (busyQ) begin
      crcQ   <= crcNext;
      bitCnt <= bitCnt + 1'b1;
      if (lastBit) busyQ <= 1'b0;
    end
  end

endmodule

// File: rtl/keyvault_ctl.sv
module keyvault_ctl
  import keyvault_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  input  logic              cfgStrict,
  input  logic [WORD_W-1:0] topWord,
  input  logic              crcBusy,
  input  logic              crcFinish,
  input  logic              crcMatch,
  output kvStrobe_t         stb,
  output logic [WORD_W-1:0] prdata,
  output logic              pslverr,
  output logic              irq
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] regIdx, keyOff;
  logic aligned, access, wrAcc, mapped, isKey, isTop, magicHit;
  logic selStatus, selCtrl, selPgm, selSum, selErrEn;
  logic selIsr, selImr, selIer, selIdr, selLock;
  logic pgmMode, zeroized, crcDone, crcPass, lockTop, errEn, isrBit, imrBit;

  assign regIdx  = paddr[ADDR_W-1:2];
  assign aligned = paddr[1:0] == 2'b00;
  assign access  = psel && penable;
  assign wrAcc   = access && pwrite;

  assign selStatus = aligned && regIdx == IDX_W'(IDX_STATUS);
  assign selCtrl   = aligned && regIdx == IDX_W'(IDX_CTRL);
  assign selPgm    = aligned && regIdx == IDX_W'(IDX_PGM);
  assign selSum    = aligned && regIdx == IDX_W'(IDX_SUM);
  assign selErrEn  = aligned && regIdx == IDX_W'(IDX_ERREN);
  assign selIsr    = aligned && regIdx == IDX_W'(IDX_ISR);
  assign selImr    = aligned && regIdx == IDX_W'(IDX_IMR);
  assign selIer    = aligned && regIdx == IDX_W'(IDX_IER);
  assign selIdr    = aligned && regIdx == IDX_W'(IDX_IDR);
  assign selLock   = aligned && regIdx == IDX_W'(IDX_LOCK);

  assign isKey  = aligned && regIdx >= IDX_W'(IDX_KEY0) && regIdx <= IDX_W'(IDX_KEYTOP);
  assign keyOff = regIdx - IDX_W'(IDX_KEY0);
  assign isTop  = isKey && keyOff == IDX_W'(NUM_KEY_WORDS - 1);
  assign mapped = aligned && (regIdx <= IDX_W'(IDX_IDR) || regIdx == IDX_W'(IDX_LOCK));

  assign magicHit = selPgm && pwdata == WORD_W'(PGM_MAGIC);

  // Strobes to the datapath
  assign stb.zeroAll  = wrAcc && ((selCtrl && pwdata[0]) || magicHit);
  assign stb.clrTop   = cfgStrict;
  assign stb.keyIdx   = keyOff[KIDX_W-1:0];
  assign stb.keyWr    = wrAcc && isKey && pgmMode && !(isTop && lockTop);
  assign stb.crcStart = wrAcc && selSum && pgmMode && !crcBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmMode  <= 1'b0;
      zeroized <= 1'b0;
      crcDone  <= 1'b0;
      crcPass  <= 1'b0;
      lockTop  <= 1'b0;
      errEn    <= 1'b0;
      isrBit   <= 1'b0;
      imrBit   <= 1'b1;
    end else begin
      if (stb.zeroAll) zeroized <= 1'b1;
      else if (stb.keyWr && pwdata != '0 && (!isTop || cfgStrict)) zeroized <= 1'b0;

      if (wrAcc && magicHit) pgmMode <= 1'b1;

      if (stb.crcStart) begin
        crcDone <= 1'b0;
        crcPass <= 1'b0;
      end else if (crcFinish) begin
        crcDone <= 1'b1;
        crcPass <= crcMatch;
      end

      if (wrAcc && selErrEn) errEn <= pwdata[0];

      if (access && !mapped && errEn) isrBit <= 1'b1;
      else if (wrAcc && selIsr && pwdata[0]) isrBit <= 1'b0;

      if (wrAcc && selIer && pwdata[0]) imrBit <= 1'b0;
      else if (wrAcc && selIdr && pwdata[0]) imrBit <= 1'b1;

      if (wrAcc && selLock && pwdata[0] && !cfgStrict) lockTop <= 1'b1;
    end
  end

  always_comb begin
    prdata = '0;
    if (selStatus) prdata[9:0] = {crcPass, crcDone, 3'b000, zeroized, 3'b000, pgmMode};
    else if (isTop && !cfgStrict) prdata = topWord;
    else if (selErrEn) prdata[0] = errEn;
    else if (selIsr) prdata[0] = isrBit;
    else if (selImr) prdata[0] = imrBit;
    else if (selLock) prdata[0] = lockTop;
  end

  assign pslverr = access && !mapped && errEn;
  assign irq     = isrBit && !imrBit;

endmodule

// File: rtl/keyvault_ctrl.sv
module keyvault_ctrl
  import keyvault_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic        irq,
  input  logic        cfgStrict
);

  kvStrobe_t   stb;
  logic [31:0] topWord;
  logic        crcBusy, crcFinish, crcMatch;

  assign pready = 1'b1;

  keyvault_ctl #(.ADDR_W(8), .WORD_W(32)) u_ctl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cfgStrict(cfgStrict), .topWord(topWord),
    .crcBusy(crcBusy), .crcFinish(crcFinish), .crcMatch(crcMatch),
    .stb(stb), .prdata(prdata), .pslverr(pslverr), .irq(irq)
  );

  keyvault_dp #(.WORD_W(32), .NUM_WORDS(NUM_KEY_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(pwdata), .cfgPad(cfgStrict),
    .topWord(topWord), .crcBusy(crcBusy), .crcFinish(crcFinish), .crcMatch(crcMatch)
  );

endmodule

// File: rtl/keyvault_chk.sv
module keyvault_chk (
  input logic        clk,
  input logic        rstN,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [7:0]  paddr,
  input logic [31:0] pwdata,
  input logic        pslverr,
  input logic        pgmMode,
  input logic        zeroized,
  input logic        crcDone,
  input logic        crcPass,
  input logic        crcBusy,
  input logic        lockTop,
  input logic        isrBit,
  input logic        imrBit
);

  // R2
  pgm_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmMode |=> pgmMode);

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockTop |=> lockTop);

  // R3
  zeroize_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && pwrite && paddr == 8'h04 && pwdata[0]) |=> zeroized);

  // R9
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    crcPass |-> crcDone);

  // R9
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    crcBusy |-> !crcDone);

  // R10
  slverr_in_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |-> (psel && penable));

  // R10
  slverr_sets_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |=> isrBit);

  // R11
  ier_unmask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && pwrite && paddr == 8'h40 && pwdata[0]) |=> !imrBit);

endmodule

bind keyvault_ctrl keyvault_chk u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pslverr(pslverr),
  .pgmMode(u_ctl.pgmMode), .zeroized(u_ctl.zeroized), .crcDone(u_ctl.crcDone),
  .crcPass(u_ctl.crcPass), .crcBusy(crcBusy), .lockTop(u_ctl.lockTop),
  .isrBit(u_ctl.isrBit), .imrBit(u_ctl.imrBit)
);

// File: tb/keyvault_ctrl_bench.sv
module keyvault_ctrl_bench;

  localparam logic [7:0] A_STATUS = 8'h00, A_CTRL = 8'h04, A_PGM = 8'h08, A_SUM = 8'h0C;
  localparam logic [7:0] A_KEY0 = 8'h10, A_TOP = 8'h30, A_ERREN = 8'h34, A_ISR = 8'h38;
  localparam logic [7:0] A_IMR = 8'h3C, A_IER = 8'h40, A_IDR = 8'h44, A_LOCK = 8'h4C;
  localparam logic [31:0] MAGIC = 32'h757B_DF0D;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, psel, penable, pwrite, pready, pslverr, irq, cfgStrict;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;

  int vecs = 0;
  int errs = 0;
  logic [31:0] keyRef [8];

  keyvault_ctrl u_keyvault_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq(irq), .cfgStrict(cfgStrict)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    e = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic e;
    busRead(a, d, e);
    check(req, d, exp);
  endtask

  task automatic doReset(input logic strict);
    @(negedge clk);
    rstN = 1'b0;
    cfgStrict = strict;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] crcRef(input logic pad);
    logic [31:0] c, word;
    logic fb;
    c = '1;
    for (int w = 0; w < 9; w++) begin
      if (w == 0 && !pad) continue;
      word = (w == 0) ? 32'h0 : keyRef[w-1];
      for (int b = 0; b < 32; b++) begin
        fb = c[0] ^ word[b];
        c = c >> 1;
        if (fb) c = c ^ 32'h82F6_3B78;
      end
    end
    return ~c;
  endfunction

  // R9: load random key, write checksum, poll for completion
  task automatic crcTrial(input logic pad, input logic good, input logic spoil);
    logic [31:0] sum, st;
    logic e;
    for (int i = 0; i < 8; i++) begin
      keyRef[i] = $urandom;
      busWrite(A_KEY0 + 8'(4 * i), keyRef[i]);
    end
    sum = crcRef(pad);
    if (!good) sum = sum ^ (32'h1 << ($urandom % 32));
    busWrite(A_SUM, sum);
    if (spoil) busWrite(A_SUM, ~sum);
    busRead(A_STATUS, st, e);
    check("R9 flags cleared while running", st & 32'h300, 32'h0);
    for (int n = 0; n < 400; n++) begin
      busRead(A_STATUS, st, e);
      if (st[8]) break;
    end
    check("R9 done/pass", 32'(st[9:8]), good ? 32'h3 : 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] d, topOld, seedDummy;
    logic e;
    seedDummy = $urandom(32'd4242);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    rstN = 1'b1; cfgStrict = 1'b0;
    doReset(1'b0);

    // R1 reset state
    expectReg("R1 status", A_STATUS, 32'h0);
    expectReg("R1 mask", A_IMR, 32'h1);
    expectReg("R1 lock", A_LOCK, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R12 pready", 32'(pready), 32'h1);

    // R12 status not writable
    busWrite(A_STATUS, 32'hFFFF_FFFF);
    expectReg("R12 status ignores write", A_STATUS, 32'h0);

    // R3 zeroize via control
    busWrite(A_CTRL, 32'h1);
    expectReg("R3 zeroized set", A_STATUS, 32'h10);
    expectReg("R3 control reads 0", A_CTRL, 32'h0);

    // R4 key write ignored outside programming mode (zeroized stays)
    busWrite(A_KEY0 + 8'h4, 32'hDEAD_BEEF);
    expectReg("R4 key write ignored", A_STATUS, 32'h10);
    busWrite(A_SUM, 32'h1234);
    expectReg("R9 checksum ignored outside pgm", A_STATUS, 32'h10);

    // R7 word 8 ignored outside programming mode
    busRead(A_TOP, topOld, e);
    busWrite(A_TOP, ~topOld);
    expectReg("R7 top write ignored", A_TOP, topOld);

    // R2 wrong magic then right magic
    busWrite(A_PGM, MAGIC ^ 32'h1);
    expectReg("R2 wrong magic", A_STATUS, 32'h10);
    busWrite(A_PGM, MAGIC);
    expectReg("R2 pgm mode set", A_STATUS, 32'h11);

    // R6 zero write keeps flag, nonzero clears it
    busWrite(A_KEY0 + 8'h8, 32'h0);
    expectReg("R6 zero write keeps flag", A_STATUS, 32'h11);
    busWrite(A_KEY0 + 8'h8, 32'h55);
    expectReg("R6 nonzero write clears flag", A_STATUS, 32'h01);
    expectReg("R4 key reads 0", A_KEY0 + 8'h8, 32'h0);
    expectReg("R4 checksum reads 0", A_SUM, 32'h0);

    // R7/R6/R5 word 8 readable config
    busWrite(A_CTRL, 32'h1);
    busWrite(A_TOP, 32'hA5A5_0001);
    expectReg("R7 top readback", A_TOP, 32'hA5A5_0001);
    expectReg("R6 top write keeps flag", A_STATUS, 32'h11);
    busWrite(A_CTRL, 32'h1);
    expectReg("R5 top kept by zeroize", A_TOP, 32'hA5A5_0001);

    // R9 random checks without padding
    for (int t = 0; t < 12; t++) crcTrial(1'b0, ($urandom % 2) == 0, 1'b0);
    crcTrial(1'b0, 1'b1, 1'b1);
    crcTrial(1'b0, 1'b0, 1'b0);

    // R8 lock
    busWrite(A_LOCK, 32'h1);
    expectReg("R8 lock set", A_LOCK, 32'h1);
    busWrite(A_TOP, 32'h0BAD_0BAD);
    expectReg("R7 locked top ignores write", A_TOP, 32'hA5A5_0001);
    busWrite(A_LOCK, 32'h0);
    expectReg("R8 lock sticky", A_LOCK, 32'h1);

    // R10 / R11
    busRead(8'h48, d, e);
    check("R10 no slverr when disabled", 32'(e), 32'h0);
    expectReg("R10 isr untouched", A_ISR, 32'h0);
    busWrite(A_ERREN, 32'h1);
    busRead(8'h48, d, e);
    check("R10 slverr", 32'(e), 32'h1);
    check("R10 unmapped reads 0", d, 32'h0);
    busRead(8'h11, d, e);
    check("R10 misaligned slverr", 32'(e), 32'h1);
    expectReg("R10 isr set", A_ISR, 32'h1);
    check("R11 irq masked", 32'(irq), 32'h0);
    busWrite(A_IER, 32'h1);
    expectReg("R11 mask cleared", A_IMR, 32'h0);
    check("R11 irq high", 32'(irq), 32'h1);
    expectReg("R11 ier reads 0", A_IER, 32'h0);
    busWrite(A_IDR, 32'h1);
    check("R11 irq masked again", 32'(irq), 32'h0);
    expectReg("R11 idr reads 0", A_IDR, 32'h0);
    busWrite(A_IER, 32'h1);
    busWrite(A_ISR, 32'h1);
    check("R11 irq after clear", 32'(irq), 32'h0);
    expectReg("R11 isr w1c", A_ISR, 32'h0);

    // R1 key survives reset
    doReset(1'b0);
    expectReg("R1 top survives reset", A_TOP, 32'hA5A5_0001);
    expectReg("R1 status after reset", A_STATUS, 32'h0);
    expectReg("R1 lock after reset", A_LOCK, 32'h0);

    // Strict configuration
    doReset(1'b1);
    busWrite(A_LOCK, 32'h1);
    expectReg("R8 strict lock stays 0", A_LOCK, 32'h0);
    busWrite(A_PGM, MAGIC);
    expectReg("R2 strict pgm", A_STATUS, 32'h11);
    busWrite(A_TOP, 32'h77);
    expectReg("R7 strict top reads 0", A_TOP, 32'h0);
    expectReg("R6 strict top write clears flag", A_STATUS, 32'h01);
    for (int t = 0; t < 12; t++) crcTrial(1'b1, ($urandom % 2) == 0, 1'b0);
    crcTrial(1'b1, 1'b1, 1'b0);
    crcTrial(1'b1, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule